// File: doc/BRIEF.md
# Quadrature Position Decoder with Register Access

This block follows one incremental encoder. It takes the two phase signals, synchronises them to the system clock and optionally inverts each one. Each phase can then pass through its own glitch filter, whose length is set in steps of four clocks. The block decodes every Gray-code edge of the phase pair into one count step, so a full encoder cycle gives four steps. The steps drive a 16-bit position register that moves up or down.

The position wraps between two programmable bounds, a start value and a limit value. Counting up past the limit reloads the start value. Counting down past the start value reloads the limit. Each wrap raises an overflow flag and records whether the wrap happened at the top or at the bottom. The flag can drive an interrupt line.

Software uses a small synchronous register bus. A write to the position register reloads it from the start value and ignores the written data. The configuration registers can be written only while a write-protect-disable bit is set. Software sets that bit through the mode register and clears it through the fault register.

Top module: `qdec_periph`

Register addresses (3-bit `addr`): 0 status/control, 1 position, 2 limit, 3 start, 4 mode, 5 fault, 6 filter, 7 decoder control.

## Requirements
- R1: With decoding enabled, each single-phase change of the phase pair {A,B} moves the position by one. The sequence 00→10→11→01→00 counts up (A leads B). The reverse sequence counts down (B leads A).
- R2: A change of both phases in the same clock leaves the position unchanged.
- R3: An up step taken while position equals limit loads the start value, sets the overflow flag (status/control bit 7) and sets the overflow-direction flag (decoder control bit 1) to 1.
- R4: A down step taken while position equals start loads the limit value, sets the overflow flag and clears the overflow-direction flag to 0.
- R5: Any bus write to the position register (address 1) loads the position from the start register, whatever the write data is.
- R6: The filter register (address 6) holds the phase A length in bits 3:0 and the phase B length in bits 7:4. Decoder control bit 7 enables the phase A filter and bit 6 enables the phase B filter.
  - An enabled filter with length N>0 rejects an input level that lasts fewer than 4·N clocks.
  - It passes a level that is held longer than that.
  - A length of 0 passes the input straight through.
- R7: Decoder control bit 5 inverts phase A and bit 4 inverts phase B. With phase A inverted, an A-leading pin sequence counts down.
- R8: Writes to status/control bit 6, the filter register, decoder control and mode bit 0 take effect only while the write-protect-disable bit (mode bit 2) is 1.
  - That bit is 1 after reset.
  - Writing 1 to mode bit 2 sets it.
  - Writing 1 to fault register bit 6 clears it.
  - Fault bit 6 reads as the inverse of the write-protect-disable bit.
- R9: The overflow flag clears only on a write of 0 to status/control bit 7 that follows a read of status/control made while the flag was set. A write of 0 without such a read leaves the flag set.
- R10: `irq_o` is 1 exactly when the overflow flag and the interrupt enable (status/control bit 6) are both 1.
- R11: The position counts only when decoder control bit 0 is 1 and bit 3 is 0. Otherwise it holds.
- R12: Decoder control bit 2 is read-only and shows the direction of the last counted step: 1 for up, 0 for down.
- R13: After reset the registers read as follows:
  - position 0, status/control 0, decoder control 0 and fault 0;
  - mode reads 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register (combinational) |
| pha_i | input | 1 | Encoder phase A pin (asynchronous) |
| phb_i | input | 1 | Encoder phase B pin (asynchronous) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The decoder is driven with directed walks around the Gray cycle in both directions, and with steps that change both phases at once. Together these separate correct x4 decoding from a reversed direction or from counting illegal jumps. A long random walk of up and down steps is run between close start and limit bounds. It is compared with a wrap model and exposes wrong wrap targets or off-by-one bound tests. The filter is given a pulse shorter than its window and a level held longer than it, which separates rejection from pass-through. Inverted-phase walks show that polarity is applied before decoding.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [2:0] {
        A_STATCTL = 3'd0,
        A_COUNT   = 3'd1,
        A_LIMIT   = 3'd2,
        A_START   = 3'd3,
        A_MODE    = 3'd4,
        A_FAULT   = 3'd5,
        A_FILTER  = 3'd6,
        A_DECCTL  = 3'd7
    } reg_addr_e;

    // decoder control bit positions
    localparam int DC_FEN_A  = 7;
    localparam int DC_FEN_B  = 6;
    localparam int DC_INV_A  = 5;
    localparam int DC_INV_B  = 4;
    localparam int DC_MODE   = 3;
    localparam int DC_DIR    = 2;
    localparam int DC_TOFDIR = 1;
    localparam int DC_QEN    = 0;

    // status/control, mode and fault bit positions
    localparam int SC_TOF    = 7;
    localparam int SC_TOIE   = 6;
    localparam int MD_WPDIS  = 2;
    localparam int MD_EN     = 0;
    localparam int FS_WPEN   = 6;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

endpackage

// File: rtl/qdec_phase_filter.sv
module qdec_phase_filter #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic          invert_i,
    input  logic          filt_en_i,
    input  logic [FW-1:0] filt_val_i,
    output logic          lvl_o
);
    localparam int CNTW = FW + 2;

    typedef struct packed {
        logic [1:0]      sync;
        logic            lvl;
        logic [CNTW-1:0] cnt;
    } filt_t;

    filt_t q, d;

    logic            src;
    logic [CNTW-1:0] win;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pin_i};
        src    = q.sync[1] ^ invert_i;
        win    = {filt_val_i, 2'b00};
        if (!filt_en_i || (filt_val_i == '0)) begin
            d.lvl = src;
            d.cnt = '0;
        end else if (src == q.lvl) begin
            d.cnt = '0;
        end else if (q.cnt == win - 1'b1) begin
            d.lvl = src;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o = q.lvl;
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  a_i,
    input  logic  b_i,
    output step_e step_o
);
    logic [1:0] prev_q, prev_d;
    logic [3:0] pair;

    always_comb begin
        prev_d = {a_i, b_i};
        pair   = {prev_q, a_i, b_i};
        unique case (pair)
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step_o = STEP_UP;
            4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: step_o = STEP_DN;
            default:                                step_o = STEP_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
    import qdec_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  step_e         step_i,
    input  logic          load_i,
    input  logic [CW-1:0] start_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] count_o,
    output logic          wrap_o,
    output logic          wrap_top_o
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d      = cnt_q;
        wrap_o     = 1'b0;
        wrap_top_o = 1'b0;
        if (load_i) begin
            cnt_d = start_i;
        end else if (run_i && step_i == STEP_UP) begin
            if (cnt_q == limit_i) begin
                cnt_d      = start_i;
                wrap_o     = 1'b1;
                wrap_top_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (run_i && step_i == STEP_DN) begin
            if (cnt_q == start_i) begin
                cnt_d  = limit_i;
                wrap_o = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/qdec_periph.sv
module qdec_periph
    import qdec_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          pha_i,
    input  logic          phb_i,
    output logic          irq_o
);
    localparam int NPH = 2;

    typedef struct packed {
        logic          tof;
        logic          tof_armed;
        logic          toie;
        logic [CW-1:0] limit;
        logic [CW-1:0] start;
        logic          wpdis;
        logic          men;
        logic [FW-1:0] flen_a;
        logic [FW-1:0] flen_b;
        logic          fen_a;
        logic          fen_b;
        logic          inv_a;
        logic          inv_b;
        logic          mode;
        logic          qen;
        logic          dir;
        logic          tofdir;
    } regs_t;

    regs_t q, d;

    reg_addr_e     ra;
    logic [NPH-1:0] pins, lvls, invs, fens;
    logic [FW-1:0]  flens [NPH];
    step_e          step;
    logic           run;
    logic           cnt_wr;
    logic           dec_wr;
    logic [CW-1:0]  cnt;
    logic           wrap, wrap_top;
    logic [5:0]     dec_cfg;

    assign ra       = reg_addr_e'(addr);
    assign pins     = {phb_i, pha_i};
    assign invs     = {q.inv_b, q.inv_a};
    assign fens     = {q.fen_b, q.fen_a};
    assign flens[0] = q.flen_a;
    assign flens[1] = q.flen_b;
    assign run      = q.qen & ~q.mode;
    assign cnt_wr   = wr_en && (ra == A_COUNT);
    assign dec_wr   = wr_en && (ra == A_DECCTL);
    assign dec_cfg  = {q.fen_a, q.fen_b, q.inv_a, q.inv_b, q.mode, q.qen};

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        qdec_phase_filter #(.FW(FW)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pins[i]),
            .invert_i  (invs[i]),
            .filt_en_i (fens[i]),
            .filt_val_i(flens[i]),
            .lvl_o     (lvls[i])
        );
    end

    qdec_step_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (lvls[0]),
        .b_i   (lvls[1]),
        .step_o(step)
    );

    qdec_pos_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .step_i    (step),
        .load_i    (cnt_wr),
        .start_i   (q.start),
        .limit_i   (q.limit),
        .count_o   (cnt),
        .wrap_o    (wrap),
        .wrap_top_o(wrap_top)
    );

    // next-state of the register file
    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (ra)
                A_STATCTL: begin
                    if (q.wpdis) d.toie = wdata[SC_TOIE];
                    if (!wdata[SC_TOF] && q.tof_armed) begin
                        d.tof       = 1'b0;
                        d.tof_armed = 1'b0;
                    end
                end
                A_LIMIT: d.limit = wdata[CW-1:0];
                A_START: d.start = wdata[CW-1:0];
                A_MODE: begin
                    if (wdata[MD_WPDIS]) d.wpdis = 1'b1;
                    if (q.wpdis)         d.men   = wdata[MD_EN];
                end
                A_FAULT: begin
                    if (wdata[FS_WPEN]) d.wpdis = 1'b0;
                end
                A_FILTER: begin
                    if (q.wpdis) begin
                        d.flen_a = wdata[FW-1:0];
                        d.flen_b = wdata[2*FW-1:FW];
                    end
                end
                A_DECCTL: begin
                    if (q.wpdis) begin
                        d.fen_a = wdata[DC_FEN_A];
                        d.fen_b = wdata[DC_FEN_B];
                        d.inv_a = wdata[DC_INV_A];
                        d.inv_b = wdata[DC_INV_B];
                        d.mode  = wdata[DC_MODE];
                        d.qen   = wdata[DC_QEN];
                    end
                end
                default: ;
            endcase
        end
        if (rd_en && (ra == A_STATCTL) && q.tof) d.tof_armed = 1'b1;
        if (run && !cnt_wr && step != STEP_NONE) d.dir = (step == STEP_UP);
        if (wrap) begin
            d.tof       = 1'b1;
            d.tof_armed = 1'b0;
            d.tofdir    = wrap_top;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.wpdis <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (ra)
            A_STATCTL: begin
                rdata[SC_TOF]  = q.tof;
                rdata[SC_TOIE] = q.toie;
            end
            A_COUNT:  rdata[CW-1:0] = cnt;
            A_LIMIT:  rdata[CW-1:0] = q.limit;
            A_START:  rdata[CW-1:0] = q.start;
            A_MODE: begin
                rdata[MD_WPDIS] = q.wpdis;
                rdata[MD_EN]    = q.men;
            end
            A_FAULT:  rdata[FS_WPEN] = ~q.wpdis;
            A_FILTER: rdata[2*FW-1:0] = {q.flen_b, q.flen_a};
            A_DECCTL: begin
                rdata[DC_FEN_A]  = q.fen_a;
                rdata[DC_FEN_B]  = q.fen_b;
                rdata[DC_INV_A]  = q.inv_a;
                rdata[DC_INV_B]  = q.inv_b;
                rdata[DC_MODE]   = q.mode;
                rdata[DC_DIR]    = q.dir;
                rdata[DC_TOFDIR] = q.tofdir;
                rdata[DC_QEN]    = q.qen;
            end
            default: ;
        endcase
    end

    assign irq_o = q.tof & q.toie;
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] start,
    input logic          cnt_wr,
    input logic          run,
    input logic [1:0]    step,
    input logic          wrap,
    input logic          tof,
    input logic          toie,
    input logic          irq,
    input logic          wpdis,
    input logic          dec_wr,
    input logic [5:0]    dec_cfg
);
    // R5: position write reloads the start value
    a_r5_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(start)));

    // R11: no counting while decoding is off
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R1: no step from the decoder means no movement
    a_r1_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 2'd0 && !cnt_wr) |=> $stable(cnt));

    // R3: a wrap always raises the overflow flag
    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tof);

    // R8: protected decoder control write is ignored
    a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_wr && !wpdis) |=> $stable(dec_cfg));

    // R10: interrupt only with flag and enable
    a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tof && toie));
endmodule

bind qdec_periph qdec_checker #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .start  (q.start),
    .cnt_wr (cnt_wr),
    .run    (run),
    .step   (step),
    .wrap   (wrap),
    .tof    (q.tof),
    .toie   (q.toie),
    .irq    (irq_o),
    .wpdis  (q.wpdis),
    .dec_wr (dec_wr),
    .dec_cfg(dec_cfg)
);

// File: tb/sim_qdec_periph.sv
module sim_qdec_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pa = 1'b0;
    logic        pb = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    localparam logic [2:0] R_SC = 3'd0, R_CNT = 3'd1, R_LIM = 3'd2, R_STA = 3'd3,
                           R_MODE = 3'd4, R_FLT = 3'd5, R_FIL = 3'd6, R_DEC = 3'd7;

    qdec_periph u0 (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .pha_i(pa),
        .phb_i(pb),
        .irq_o(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] up_next(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] dn_next(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [15:0] m_up(input logic [15:0] c, lim, sta);
        return (c == lim) ? sta : c + 16'd1;
    endfunction

    function automatic logic [15:0] m_dn(input logic [15:0] c, lim, sta);
        return (c == sta) ? lim : c - 16'd1;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pins(input logic [1:0] s, input int hold);
        @(negedge clk);
        pa = s[1]; pb = s[0];
        repeat (hold) @(negedge clk);
    endtask

    task automatic go_up();
        pins(up_next({pa, pb}), 6);
    endtask

    task automatic go_dn();
        pins(dn_next({pa, pb}), 6);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, base, c, lim, sta;
        logic [1:0]  s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        rd(R_CNT, v);  check("R13 count", v, 16'h0000);
        rd(R_MODE, v); check("R13 mode", v, 16'h0004);
        rd(R_DEC, v);  check("R13 decctl", v, 16'h0000);
        rd(R_SC, v);   check("R13 statctl", v, 16'h0000);
        rd(R_FLT, v);  check("R13 fault", v, 16'h0000);

        // R1, R12 basic x4 counting
        wr(R_LIM, 16'hFFFF);
        wr(R_STA, 16'h0000);
        wr(R_DEC, 16'h0001);
        wr(R_CNT, 16'h0000);
        for (int i = 0; i < 4; i++) go_up();
        rd(R_CNT, v); check("R1 up four", v, 16'd4);
        rd(R_DEC, v); check("R12 dir up", v & 16'h0004, 16'h0004);
        go_dn(); go_dn();
        rd(R_CNT, v); check("R1 down two", v, 16'd2);
        rd(R_DEC, v); check("R12 dir down", v & 16'h0004, 16'h0000);

        // R2 both phases at once
        pins({~pa, ~pb}, 6);
        rd(R_CNT, v); check("R2 double change", v, 16'd2);
        pins({~pa, ~pb}, 6);
        rd(R_CNT, v); check("R2 double change back", v, 16'd2);

        // R5 position write loads start
        wr(R_STA, 16'h1234);
        wr(R_CNT, 16'hBEEF);
        rd(R_CNT, v); check("R5 load start", v, 16'h1234);

        // R3 top wrap, R9 flag clearing
        wr(R_STA, 16'd2);
        wr(R_LIM, 16'd5);
        wr(R_CNT, 16'h0000);
        for (int i = 0; i < 3; i++) go_up();
        rd(R_CNT, v); check("R3 at limit", v, 16'd5);
        go_up();
        rd(R_CNT, v); check("R3 wrap to start", v, 16'd2);
        rd(R_SC, v);  check("R3 flag set", v & 16'h0080, 16'h0080);
        rd(R_DEC, v); check("R3 top dir", v & 16'h0002, 16'h0002);
        wr(R_SC, 16'h0000);  // armed by read above, so issue fresh wrap first
        wr(R_CNT, 16'h0);    // count back to 2
        go_dn();             // 2 -> 5 bottom wrap, re-sets flag and disarms
        rd(R_CNT, v); check("R4 wrap to limit", v, 16'd5);
        rd(R_DEC, v); check("R4 bottom dir", v & 16'h0002, 16'h0000);
        @(negedge clk);
        wr(R_SC, 16'h0000);
        addr = R_SC; #2 v = rdata;
        check("R9 write without read keeps flag", v & 16'h0080, 16'h0080);
        rd(R_SC, v);
        wr(R_SC, 16'h0000);
        rd(R_SC, v); check("R9 read then write clears", v & 16'h0080, 16'h0000);

        // R10 interrupt
        wr(R_SC, 16'h0040);
        #2 check("R10 irq low", {15'd0, irq}, 16'd0);
        wr(R_CNT, 16'h0);  // count = 2
        go_dn();
        #2 check("R10 irq high", {15'd0, irq}, 16'd1);
        rd(R_SC, v);
        wr(R_SC, 16'h0040);
        #2 check("R10 irq cleared", {15'd0, irq}, 16'd0);

        // R7 polarity
        wr(R_LIM, 16'hFFFF);
        wr(R_STA, 16'h0100);
        wr(R_CNT, 16'h0);
        wr(R_STA, 16'h0000);
        wr(R_DEC, 16'h0021);
        repeat (6) @(negedge clk);
        rd(R_CNT, base);
        go_up();
        rd(R_CNT, v); check("R7 inverted A counts down", v, base - 16'd1);
        go_up();
        rd(R_CNT, v); check("R7 inverted A second", v, base - 16'd2);
        wr(R_DEC, 16'h0001);
        repeat (6) @(negedge clk);

        // R6 filter on phase A: length 2 -> 8 clocks
        wr(R_FIL, 16'h0002);
        wr(R_DEC, 16'h0081);
        rd(R_CNT, base);
        s = {~pa, pb};
        pins(s, 5);
        pins({~pa, pb}, 12);
        rd(R_CNT, v); check("R6 short pulse rejected", v, base);
        rd(R_FIL, v); check("R6 filter field", v, 16'h0002);
        s = {~pa, pb};
        c = (s == up_next({pa, pb})) ? base + 16'd1 : base - 16'd1;
        pins(s, 20);
        rd(R_CNT, v); check("R6 long level passes", v, c);
        wr(R_FIL, 16'h0000);
        base = v;
        s = {~pa, pb};
        c = (s == up_next({pa, pb})) ? base + 16'd1 : base - 16'd1;
        pins(s, 6);
        rd(R_CNT, v); check("R6 zero length passthrough", v, c);
        wr(R_DEC, 16'h0001);

        // R8 write protection
        wr(R_FLT, 16'h0040);
        rd(R_MODE, v); check("R8 wpdis cleared", v, 16'h0000);
        rd(R_FLT, v);  check("R8 fault reads protect", v, 16'h0040);
        wr(R_DEC, 16'h0000);
        rd(R_DEC, v);  check("R8 decctl protected", v & 16'h00F9, 16'h0001);
        wr(R_FIL, 16'h0033);
        rd(R_FIL, v);  check("R8 filter protected", v, 16'h0000);
        wr(R_SC, 16'h0000);
        rd(R_SC, v);   check("R8 toie protected", v & 16'h0040, 16'h0040);
        rd(R_CNT, base);
        go_up();
        rd(R_CNT, v);  check("R8 still counting", v, base + 16'd1);
        wr(R_MODE, 16'h0004);
        rd(R_MODE, v); check("R8 wpdis set", v, 16'h0004);
        wr(R_MODE, 16'h0005);
        rd(R_MODE, v); check("R8 enable bit writable", v, 16'h0005);

        // R11 hold when disabled or other mode
        wr(R_DEC, 16'h0000);
        rd(R_CNT, base);
        go_up();
        rd(R_CNT, v); check("R11 hold qen=0", v, base);
        wr(R_DEC, 16'h0009);
        go_up();
        rd(R_CNT, v); check("R11 hold mode=1", v, base);
        wr(R_DEC, 16'h0001);
        go_up();
        rd(R_CNT, v); check("R11 counts again", v, base + 16'd1);

        // R1 R3 R4 random walk against wrap model
        sta = 16'd100 + 16'($urandom % 16);
        lim = sta + 16'd3 + 16'($urandom % 6);
        wr(R_STA, sta);
        wr(R_LIM, lim);
        wr(R_CNT, 16'h0);
        c = sta;
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 2) begin
                go_up(); c = m_up(c, lim, sta);
            end else begin
                go_dn(); c = m_dn(c, lim, sta);
            end
            rd(R_CNT, v); check("R1 random walk", v, c);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule